// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the event pulses raised by a set of DMA channels and turns them into one interrupt line for the processor. Each channel owns a five-bit sticky event status and a five-bit event mask. When any unmasked event of a channel is set, that channel's bit in the global pending register comes on. A global enable register then selects which pending bits may drive the interrupt line. A third global register reports which channels are idle, taken from the busy flags the channels present.

Software services an interrupt in a fixed order. It first clears the channel's event status by writing back the value it read with the handled bits set to zero. Then it clears the pending bit by writing a one to it. The pending bit follows the channel's masked status as a level, not as an edge. If an unmasked event is still set when software clears the pending bit, the bit comes back at once, so a late event is never lost. Every register is reached through a 32-bit port. Window 0 holds the global registers, and each channel gets its own window at a fixed stride above it. Reads return one cycle after the address is presented.

Top module: `dma_irq_agg`

## Requirements
- R1: After synchronous reset, all event status, event masks, pending bits and global enables are 0, irq is 0 and reg_rdata is 0.
- R2: A pulse on event bit b of channel i (bit 0 block done, 1 super-block done, 2 frame done, 3 half frame, 4 last frame) sets bit b of that channel's status register at address 0x100*(i+1)+0x44. The bit stays set after the pulse ends.
- R3: A write to a channel status register clears each bit whose write data is 0 and leaves alone each bit whose write data is 1, so software cannot set a status bit. An event arriving in the same cycle as such a write still sets its bit.
- R4: The channel mask register at address 0x100*(i+1)+0x40 holds write-data bits 4:0 and reads bits 31:5 as 0.
- R5: Bit i of the pending register (address 0x00) becomes 1 on the same clock edge that an event lands on channel i with an event bit that is both set and unmasked. An event whose mask bit is 0 does not set it.
- R6: Writing 1 to a pending bit clears it and writing 0 has no effect. If the channel still has a set, unmasked status bit, the pending bit stays 1 after the clear.
- R7: When a new unmasked event on channel i and a write of 1 to pending bit i land in the same cycle, the pending bit stays 1.
- R8: The enable register (address 0x10) holds one bit per channel. irq is a register that equals the OR of (pending AND enable) as it stood one cycle earlier. With all enables 0, irq stays 0.
- R9: The idle register (address 0x2C) reads bit i as 1 when ch_busy[i] is 0.
- R10: The unused pending and enable banks (0x04, 0x08, 0x0C, 0x14, 0x18, 0x1C) read 0 and ignore writes. Unmapped offsets and windows above the last channel also read 0.
- R11: reg_rdata is registered. It shows the register selected by reg_addr in one cycle, with the value it held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_evt | input | NUM_CH*5 | Event pulses; channel i uses bits [5i+4:5i] |
| ch_busy | input | NUM_CH | Busy flag per channel |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wen | input | 1 | Write strobe for reg_addr / reg_wdata |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
Events are driven both on masked bits and on unmasked bits. This shows that the pending register follows the masked status and not the raw status. Pending clears are tried in three cases: with the channel status still set, with it already cleared, and together with a new event in the same cycle. Together these separate a level-derived pending bit from an edge-captured one, and show which side wins a collision. Status writes use patterns that mix 0 and 1 bits, including all ones on an empty register, which tells a write-zero-to-clear register apart from a plain write or a write-one-to-clear one. Reads of the unused banks after writes, and a read whose address changes just before the edge, check the decode and the one-cycle read latency.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int EVT_W = 5;

  typedef enum logic [2:0] {
    EV_BLOCK      = 3'd0,
    EV_SUPERBLOCK = 3'd1,
    EV_FRAME      = 3'd2,
    EV_HALFFRAME  = 3'd3,
    EV_LASTFRAME  = 3'd4
  } evt_bit_e;

  // byte offsets inside a window (window 0 = global, window i+1 = channel i)
  localparam logic [7:0] G_PEND = 8'h00;
  localparam logic [7:0] G_EN   = 8'h10;
  localparam logic [7:0] G_IDLE = 8'h2C;
  localparam logic [7:0] C_MASK = 8'h40;
  localparam logic [7:0] C_STAT = 8'h44;
endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
  import dirq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 12,
  parameter int WIN_LOG2 = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output logic              sel_pend,
  output logic              sel_en,
  output logic              sel_idle,
  output logic [NUM_CH-1:0] sel_mask,
  output logic [NUM_CH-1:0] sel_stat,
  output logic              we_pend,
  output logic              we_en,
  output logic [NUM_CH-1:0] we_mask,
  output logic [NUM_CH-1:0] we_stat
);
  localparam int WIN_W = ADDR_W - WIN_LOG2;

  logic [WIN_W-1:0]    win;
  logic [WIN_LOG2-1:0] off;

  assign win = addr[ADDR_W-1:WIN_LOG2];
  assign off = addr[WIN_LOG2-1:0];

  assign sel_pend = (win == '0) && (off == WIN_LOG2'(G_PEND));
  assign sel_en   = (win == '0) && (off == WIN_LOG2'(G_EN));
  assign sel_idle = (win == '0) && (off == WIN_LOG2'(G_IDLE));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel_mask[c] = (win == WIN_W'(c + 1)) && (off == WIN_LOG2'(C_MASK));
    assign sel_stat[c] = (win == WIN_W'(c + 1)) && (off == WIN_LOG2'(C_STAT));
  end

  assign we_pend = wen & sel_pend;
  assign we_en   = wen & sel_en;
  assign we_mask = {NUM_CH{wen}} & sel_mask;
  assign we_stat = {NUM_CH{wen}} & sel_stat;
endmodule

// File: rtl/dirq_chan.sv
module dirq_chan
  import dirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] mask_q,
  output logic [EVT_W-1:0] stat_q,
  output logic             hit
);
  logic [EVT_W-1:0] keep;

  // write-zero clears a bit, write-one keeps it
  assign keep = stat_we ? wdata : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      stat_q <= (stat_q & keep) | evt;
    end
  end

  // includes this cycle's events so a same-cycle pending clear loses
  assign hit = |(mask_q & (stat_q | evt));
endmodule

// File: rtl/dirq_glob.sv
module dirq_glob #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit,
  input  logic              pend_we,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] en_q,
  output logic              irq_q
);
  logic [NUM_CH-1:0] clr;

  assign clr = pend_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | hit;
      if (en_we) en_q <= wdata;
      irq_q <= |(pend_q & en_q);
    end
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dirq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 12,
  parameter int WIN_LOG2 = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*EVT_W-1:0] ch_evt,
  input  logic [NUM_CH-1:0]       ch_busy,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wen,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    irq
);
  logic              sel_pend, sel_en, sel_idle, we_pend, we_en;
  logic [NUM_CH-1:0] sel_mask, sel_stat, we_mask, we_stat;
  logic [NUM_CH-1:0] chan_hit, pend_q, en_q;
  logic [NUM_CH*EVT_W-1:0] mask_flat, stat_flat;
  logic [31:0] rd_next;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata;

  dirq_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .addr(reg_addr), .wen(reg_wen),
    .sel_pend(sel_pend), .sel_en(sel_en), .sel_idle(sel_idle),
    .sel_mask(sel_mask), .sel_stat(sel_stat),
    .we_pend(we_pend), .we_en(we_en), .we_mask(we_mask), .we_stat(we_stat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dirq_chan u_chan (
      .clk(clk), .rst(rst),
      .evt(ch_evt[c*EVT_W +: EVT_W]),
      .mask_we(we_mask[c]), .stat_we(we_stat[c]),
      .wdata(reg_wdata[EVT_W-1:0]),
      .mask_q(mask_flat[c*EVT_W +: EVT_W]),
      .stat_q(stat_flat[c*EVT_W +: EVT_W]),
      .hit(chan_hit[c])
    );
  end

  dirq_glob #(.NUM_CH(NUM_CH)) u_glob (
    .clk(clk), .rst(rst), .hit(chan_hit),
    .pend_we(we_pend), .en_we(we_en), .wdata(reg_wdata[NUM_CH-1:0]),
    .pend_q(pend_q), .en_q(en_q), .irq_q(irq)
  );

  always_comb begin
    rd_next = '0;
    if (sel_pend) rd_next[NUM_CH-1:0] = pend_q;
    if (sel_en)   rd_next[NUM_CH-1:0] = en_q;
    if (sel_idle) rd_next[NUM_CH-1:0] = ~ch_busy;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_mask[c]) rd_next[EVT_W-1:0] = mask_flat[c*EVT_W +: EVT_W];
      if (sel_stat[c]) rd_next[EVT_W-1:0] = stat_flat[c*EVT_W +: EVT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/dirq_chk.sv
module dirq_chk
  import dirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic                    reg_wen,
  input logic [31:0]             reg_wdata,
  input logic [31:0]             reg_rdata,
  input logic                    irq,
  input logic [NUM_CH*EVT_W-1:0] ch_evt,
  input logic [NUM_CH*EVT_W-1:0] stat_flat,
  input logic [NUM_CH-1:0]       chan_hit,
  input logic [NUM_CH-1:0]       pend_q,
  input logic [NUM_CH-1:0]       en_q
);
  logic [NUM_CH-1:0] clr_mask;
  logic              bank_addr;
  logic              unused_chk;

  assign unused_chk = ^reg_wdata;
  assign clr_mask = (reg_wen && reg_addr == '0) ? reg_wdata[NUM_CH-1:0] : '0;
  assign bank_addr = (reg_addr == ADDR_W'(4))  || (reg_addr == ADDR_W'(8))  ||
                     (reg_addr == ADDR_W'(12)) || (reg_addr == ADDR_W'(20)) ||
                     (reg_addr == ADDR_W'(24)) || (reg_addr == ADDR_W'(28));

  p_evt_sets_status_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ch_evt) & ~stat_flat) == '0));

  p_hit_sets_pend_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(chan_hit) & ~pend_q) == '0));

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~$past(clr_mask) & ~pend_q) == '0));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);

  p_bank_zero_r10: assert property (@(posedge clk) disable iff (rst)
    bank_addr |=> (reg_rdata == '0));
endmodule

bind dma_irq_agg dirq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .ch_evt(ch_evt), .stat_flat(stat_flat), .chan_hit(chan_hit),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/tb_dma_irq_agg.sv
module tb_dma_irq_agg;
  localparam int N  = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*5-1:0] ch_evt = '0;
  logic [N-1:0]  ch_busy = '1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_irq_agg #(.NUM_CH(N), .ADDR_W(AW), .WIN_LOG2(8)) dut (
    .clk(clk), .rst(rst), .ch_evt(ch_evt), .ch_busy(ch_busy),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] a_mask(int ch);
    return AW'(12'h140 + ch * 12'h100);
  endfunction
  function automatic logic [AW-1:0] a_stat(int ch);
    return AW'(12'h144 + ch * 12'h100);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wen = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string req);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic pulse(int ch, logic [4:0] bits);
    @(negedge clk);
    ch_evt[ch*5 +: 5] = bits;
    @(negedge clk);
    ch_evt = '0;
  endtask

  task automatic t_reset;
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
    check(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    rd_chk(12'h000, 0, "R1 pend");
    rd_chk(12'h010, 0, "R1 en");
    rd_chk(a_mask(0), 0, "R1 mask");
    rd_chk(a_stat(7), 0, "R1 stat");
  endtask

  task automatic t_status;
    pulse(2, 5'b10100);
    rd_chk(a_stat(2), 32'h14, "R2 sticky status");
    rd_chk(12'h000, 0, "R5 masked event no pend");
    wr(a_stat(2), 32'h1B);
    rd_chk(a_stat(2), 32'h10, "R3 write-zero clears");
    wr(a_stat(3), 32'hFFFF_FFFF);
    rd_chk(a_stat(3), 0, "R3 cannot set");
    // event in the same cycle as a clearing write wins
    @(negedge clk);
    reg_addr = a_stat(2); reg_wdata = 0; reg_wen = 1'b1;
    ch_evt[2*5 +: 5] = 5'b00001;
    @(negedge clk);
    reg_wen = 1'b0; ch_evt = '0;
    rd_chk(a_stat(2), 32'h01, "R3 event beats clear");
  endtask

  task automatic t_mask;
    wr(a_mask(5), 32'hFFFF_FFFF);
    rd_chk(a_mask(5), 32'h1F, "R4 mask width");
  endtask

  task automatic t_pend_irq;
    wr(a_mask(1), 32'h01);
    pulse(1, 5'b00100);
    rd_chk(12'h000, 0, "R5 unmasked bit only");
    pulse(1, 5'b00001);
    rd_chk(12'h000, 32'h02, "R5 pend set");
    check(irq == 1'b0, "R8 disabled irq", {31'd0, irq}, 0);
    wr(12'h010, 32'h02);
    check(irq == 1'b0, "R8 irq latency", {31'd0, irq}, 0);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq on", {31'd0, irq}, 1);
    rd_chk(12'h010, 32'h02, "R8 enable readback");
    wr(12'h000, 32'h02);
    rd_chk(12'h000, 32'h02, "R6 reasserts while status set");
    wr(12'h000, 32'h00);
    rd_chk(12'h000, 32'h02, "R6 write zero no effect");
    wr(a_stat(1), 32'h0);
    rd_chk(a_stat(1), 0, "R3 status cleared");
    wr(12'h000, 32'h02);
    rd_chk(12'h000, 0, "R6 pend cleared");
    check(irq == 1'b0, "R8 irq off", {31'd0, irq}, 0);
    wr(12'h010, 32'h00);
  endtask

  task automatic t_race;
    wr(a_mask(4), 32'h08);
    pulse(4, 5'b01000);
    rd_chk(12'h000, 32'h10, "R5 ch4 pend");
    wr(a_stat(4), 32'h0);
    @(negedge clk);
    reg_addr = 12'h000; reg_wdata = 32'h10; reg_wen = 1'b1;
    ch_evt[4*5 +: 5] = 5'b01000;
    @(negedge clk);
    reg_wen = 1'b0; ch_evt = '0;
    rd_chk(12'h000, 32'h10, "R7 event beats clear");
    rd_chk(a_stat(4), 32'h08, "R7 status");
  endtask

  task automatic t_idle;
    @(negedge clk);
    ch_busy = 8'hA5;
    rd_chk(12'h02C, 32'h5A, "R9 idle");
    ch_busy = 8'h00;
    rd_chk(12'h02C, 32'hFF, "R9 all idle");
  endtask

  task automatic t_banks;
    wr(12'h010, 32'h01);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd_chk(12'h004, 0, "R10 pend bank1");
    rd_chk(12'h008, 0, "R10 pend bank2");
    rd_chk(12'h00C, 0, "R10 pend bank3");
    rd_chk(12'h014, 0, "R10 en bank1");
    rd_chk(12'h018, 0, "R10 en bank2");
    rd_chk(12'h01C, 0, "R10 en bank3");
    rd_chk(12'h010, 32'h01, "R10 en0 untouched");
    rd_chk(12'h020, 0, "R10 unmapped global");
    rd_chk(12'h148, 0, "R10 unmapped channel offset");
    rd_chk(12'h944, 0, "R10 window past last channel");
    wr(12'h010, 32'h00);
  endtask

  task automatic t_latency;
    rd_chk(a_mask(5), 32'h1F, "R11 first read");
    @(negedge clk);
    reg_addr = a_stat(4);
    #1;
    check(reg_rdata == 32'h1F, "R11 holds before edge", reg_rdata, 32'h1F);
    @(negedge clk);
    check(reg_rdata == 32'h08, "R11 new value after edge", reg_rdata, 32'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_status;
    t_mask;
    t_pend_irq;
    t_race;
    t_idle;
    t_banks;
    t_latency;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule